// File: doc/BRIEF.md
# Line-Counted Vertical Blanking Generator

This block produces the vertical blanking pulse for a raster deflection controller. All of its timing is expressed in whole lines. A line tick marks the start of every line and is aligned to the leading edge of horizontal sync. The outputs change only on these ticks, so the pulse always begins and ends on a line boundary. The block is told the index of the line that is starting, the length of the field, the accepted vertical sync event with the parity of the field it opens, the first and last lines of the vertical scan, and a small set of control fields.

There are two placement modes. In fixed-length mode the pulse has a programmed number of lines. It is anchored at the last line of the field, which is the reference point just before the vertical flyback. Pulses longer than the nominal 21-line flyback are centred around that notional flyback, with a half-line difference that depends on field parity. In scan-window mode the pulse covers the region from the end of scan to the start of the next scan. The window can be widened on both sides by a programmed extension that is split between the two sides according to parity.

A second output follows the main pulse and can optionally hold its trailing edge for six extra lines.

Top module: `vbl_gen`

## Requirements
- R1: Both outputs are low after reset. They change only in the clock cycle that follows a cycle with `line_tick` high, and that cycle shows the value for the line that just started.
- R2: In fixed-length mode (`mode_scan`=0) with `bsel_en`=1, the pulse length in lines is `blank_len` clamped to the range 16 to 127. Values below 16 give 16 and values above 127 give 127.
- R3: In fixed-length mode with `bsel_en`=0, the pulse is exactly 21 lines long and `blank_len` has no effect.
- R4: In fixed-length mode, a pulse of 21 lines or fewer starts at line `field_len`-1, which is the last line of the field.
- R5: In fixed-length mode, a pulse of length L > 21 starts (L-21)/2 lines before line `field_len`-1 when the ending field is odd, and (L-20)/2 lines before it when the ending field is even. Both halvings truncate.
- R6: In scan-window mode (`mode_scan`=1) with `bsel_en`=1 and an extension of 0, the pulse covers line `scan_end` through line `scan_start`-1 of the next field.
- R7: In scan-window mode with `bsel_en`=1 and extension E, the pulse starts E/2 lines before `scan_end` in an even field and (E+1)/2 lines before it in an odd field. It is released (E+1)/2 lines after `scan_start` in an even field and E/2 lines after it in an odd field. Each rule uses the parity of the field in which that edge falls.
- R8: In scan-window mode, the extension E is `blank_len` modulo 128, so a value above 127 acts as that value minus 128.
- R9: In scan-window mode with `bsel_en`=0, the pulse starts 4 lines before `scan_end` and is released 4 lines after `scan_start`, whatever the parity.
- R10: `vblank_ext` is high whenever `vblank` is high. With `ext_en`=1 it stays high for exactly 6 further lines after `vblank` falls. With `ext_en`=0 it equals `vblank`.
- R11: Field parity is taken from `field_odd` only in a cycle with `vsync_evt` high, and is held for the whole field. `field_odd` has no effect on any other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_tick | input | 1 | One-cycle pulse at the start of each line |
| vsync_evt | input | 1 | Accepted vertical sync; only valid together with `line_tick`, on line 0 |
| field_odd | input | 1 | Parity of the field that starts with `vsync_evt` (1 = odd) |
| line_num | input | LINE_W | Index of the line starting at this tick (0 = first line of the field) |
| field_len | input | LINE_W | Number of lines in the field |
| scan_start | input | LINE_W | First scanned line (start-of-scan reference) |
| scan_end | input | LINE_W | End-of-scan reference line |
| mode_scan | input | 1 | 0 = fixed-length mode, 1 = scan-window mode |
| bsel_en | input | 1 | 1 = use `blank_len`, 0 = use built-in defaults |
| blank_len | input | VBT_W | Programmed length (fixed mode) or extension (scan mode) |
| ext_en | input | 1 | Enables the 6-line trailing stretch on `vblank_ext` |
| vblank | output | 1 | Vertical blanking pulse |
| vblank_ext | output | 1 | Blanking pulse with optional stretched trailing edge |

## Verification
The bench targets the clamp boundaries of the length: a value of 3 must give 16 lines and a value of 200 must give 127. A design without the clamp would produce a short pulse or a 200-line pulse that runs deep into the next field. The odd-length cases of 25 and 26 lines and the extension of 7 in scan-window mode separate the odd-field and even-field offsets. Swapped parity rules or rounding instead of truncation shift an edge by one line. An extension of 135 checks the modulo-128 rule; a design that kept bit 7 would widen the window by 64 lines on each side.

Throughout every run, `field_odd` carries the opposite parity on every line except the vsync line. A design that sampled parity on every line would move edges. The trailing stretch is checked for exactly six lines; an off-by-one counter gives five or seven.

// File: rtl/vbl_pkg.sv
package vbl_pkg;

    typedef enum logic {
        VB_FIXED = 1'b0,
        VB_SCAN  = 1'b1
    } vb_mode_e;

endpackage

// File: rtl/vbl_offsets.sv
// Combinational placement math: pulse length and edge lines for both modes.
module vbl_offsets #(
    parameter int LINE_W      = 10,
    parameter int VBT_W       = 8,
    parameter int DEF_LINES   = 21,
    parameter int MIN_LINES   = 16,
    parameter int MAX_LINES   = 127,
    parameter int GUARD_LINES = 4,
    localparam int CNT_W      = $clog2(MAX_LINES + 1),
    localparam int EXT_W      = VBT_W - 1
) (
    input  logic              bsel_en,
    input  logic [VBT_W-1:0]  blank_len,
    input  logic              odd,
    input  logic [LINE_W-1:0] field_len,
    input  logic [LINE_W-1:0] scan_start,
    input  logic [LINE_W-1:0] scan_end,
    output logic [CNT_W-1:0]  fix_len,
    output logic [LINE_W-1:0] fix_set,
    output logic [LINE_W-1:0] scan_set,
    output logic [LINE_W-1:0] scan_clr
);
    logic [CNT_W-1:0] fix_off;
    logic [EXT_W-1:0] ext;
    logic [EXT_W:0]   half_dn;
    logic [EXT_W:0]   half_up;
    logic [EXT_W:0]   lead;
    logic [EXT_W:0]   trail;

    // R2 / R3: length clamp or default
    always_comb begin
        if (!bsel_en)
            fix_len = CNT_W'(DEF_LINES);
        else if (blank_len < VBT_W'(MIN_LINES))
            fix_len = CNT_W'(MIN_LINES);
        else if (blank_len > VBT_W'(MAX_LINES))
            fix_len = CNT_W'(MAX_LINES);
        else
            fix_len = blank_len[CNT_W-1:0];
    end

    // R4 / R5: centring around a notional default-length flyback
    always_comb begin
        if (fix_len <= CNT_W'(DEF_LINES))
            fix_off = '0;
        else if (odd)
            fix_off = (fix_len - CNT_W'(DEF_LINES)) >> 1;
        else
            fix_off = (fix_len - CNT_W'(DEF_LINES - 1)) >> 1;
        fix_set = field_len - LINE_W'(1) - LINE_W'(fix_off);
    end

    // R7 / R8 / R9: scan window widening, split by parity
    always_comb begin
        ext     = blank_len[EXT_W-1:0];
        half_dn = {1'b0, ext} >> 1;
        half_up = ({1'b0, ext} + (EXT_W+1)'(1)) >> 1;
        if (!bsel_en) begin
            lead  = (EXT_W+1)'(GUARD_LINES);
            trail = (EXT_W+1)'(GUARD_LINES);
        end else begin
            lead  = odd ? half_up : half_dn;
            trail = odd ? half_dn : half_up;
        end
        scan_set = scan_end - LINE_W'(lead);
        scan_clr = scan_start + LINE_W'(trail);
    end

endmodule

// File: rtl/vbl_stretch.sv
// Trailing-edge stretch for the extended blanking output.
module vbl_stretch #(
    parameter int STRETCH = 6,
    localparam int TW     = $clog2(STRETCH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    input  logic ext_en,
    input  logic main_d,
    output logic ext_q
);
    typedef struct packed {
        logic          ext;
        logic [TW-1:0] tail;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (line_tick) begin
            if (main_d) begin
                s_d.tail = TW'(STRETCH);
                s_d.ext  = 1'b1;
            end else begin
                s_d.ext = ext_en && (s_q.tail != '0);
                if (s_q.tail != '0)
                    s_d.tail = s_q.tail - TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign ext_q = s_q.ext;

endmodule

// File: rtl/vbl_gen.sv
module vbl_gen
    import vbl_pkg::*;
#(
    parameter int LINE_W      = 10,
    parameter int VBT_W       = 8,
    parameter int DEF_LINES   = 21,
    parameter int MIN_LINES   = 16,
    parameter int MAX_LINES   = 127,
    parameter int GUARD_LINES = 4,
    parameter int STRETCH     = 6,
    localparam int CNT_W      = $clog2(MAX_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic              vsync_evt,
    input  logic              field_odd,
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] field_len,
    input  logic [LINE_W-1:0] scan_start,
    input  logic [LINE_W-1:0] scan_end,
    input  logic              mode_scan,
    input  logic              bsel_en,
    input  logic [VBT_W-1:0]  blank_len,
    input  logic              ext_en,
    output logic              vblank,
    output logic              vblank_ext
);
    typedef struct packed {
        logic             par;
        logic             blank;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    logic              par_eff;
    logic [CNT_W-1:0]  fix_len;
    logic [LINE_W-1:0] fix_set;
    logic [LINE_W-1:0] scan_set;
    logic [LINE_W-1:0] scan_clr;
    vb_mode_e          mode;

    // R11: new parity is visible on the vsync line itself, then held
    assign par_eff = vsync_evt ? field_odd : s_q.par;
    assign mode    = vb_mode_e'(mode_scan);

    vbl_offsets #(
        .LINE_W(LINE_W), .VBT_W(VBT_W), .DEF_LINES(DEF_LINES),
        .MIN_LINES(MIN_LINES), .MAX_LINES(MAX_LINES), .GUARD_LINES(GUARD_LINES)
    ) u_off (
        .bsel_en   (bsel_en),
        .blank_len (blank_len),
        .odd       (par_eff),
        .field_len (field_len),
        .scan_start(scan_start),
        .scan_end  (scan_end),
        .fix_len   (fix_len),
        .fix_set   (fix_set),
        .scan_set  (scan_set),
        .scan_clr  (scan_clr)
    );

    always_comb begin
        s_d = s_q;
        if (line_tick) begin
            if (vsync_evt)
                s_d.par = field_odd;
            if (mode == VB_FIXED) begin
                if (s_q.blank) begin
                    if (s_q.cnt == '0)
                        s_d.blank = 1'b0;
                    else
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                end else if (line_num == fix_set) begin
                    s_d.blank = 1'b1;
                    s_d.cnt   = fix_len - CNT_W'(1);
                end
            end else begin
                if (line_num == scan_set)
                    s_d.blank = 1'b1;
                else if (line_num == scan_clr)
                    s_d.blank = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    vbl_stretch #(.STRETCH(STRETCH)) u_str (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_tick(line_tick),
        .ext_en   (ext_en),
        .main_d   (s_d.blank),
        .ext_q    (vblank_ext)
    );

    assign vblank = s_q.blank;

endmodule

// File: rtl/vbl_gen_chk.sv
module vbl_gen_chk #(
    parameter int MAX_LINES = 127,
    localparam int RW       = $clog2(MAX_LINES + 2)
) (
    input logic clk,
    input logic rst_n,
    input logic line_tick,
    input logic mode_scan,
    input logic vblank,
    input logic vblank_ext
);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_q <= '0;
        else if (mode_scan || !vblank)
            run_q <= '0;
        else if (line_tick && run_q != '1)
            run_q <= run_q + RW'(1);
    end

    p_edge_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vblank) |-> $past(line_tick));

    p_ext_edge_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vblank_ext) |-> $past(line_tick));

    p_ext_covers_main_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |-> vblank_ext);

    p_ext_falls_after_main_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vblank_ext) |-> !vblank);

    p_fixed_len_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(MAX_LINES));

endmodule

bind vbl_gen vbl_gen_chk #(.MAX_LINES(MAX_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_tick (line_tick),
    .mode_scan (mode_scan),
    .vblank    (vblank),
    .vblank_ext(vblank_ext)
);

// File: tb/sim_vbl_gen.sv
`timescale 1ns/1ps
module sim_vbl_gen;
    localparam int NL    = 300;
    localparam int FIELDS = 3;
    localparam int BLN   = 280;
    localparam int CLN   = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_tick = 1'b0;
    logic       vsync_evt = 1'b0;
    logic       field_odd = 1'b0;
    logic [9:0] line_num = '0;
    logic [9:0] field_len = 10'(NL);
    logic [9:0] scan_start = 10'(CLN);
    logic [9:0] scan_end = 10'(BLN);
    logic       mode_scan = 1'b0;
    logic       bsel_en = 1'b0;
    logic [7:0] blank_len = '0;
    logic       ext_en = 1'b0;
    logic       vblank;
    logic       vblank_ext;

    always #4 clk = ~clk;

    vbl_gen u0 (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .vsync_evt(vsync_evt),
        .field_odd(field_odd), .line_num(line_num), .field_len(field_len),
        .scan_start(scan_start), .scan_end(scan_end), .mode_scan(mode_scan),
        .bsel_en(bsel_en), .blank_len(blank_len), .ext_en(ext_en),
        .vblank(vblank), .vblank_ext(vblank_ext)
    );

    typedef struct {
        bit m;
        bit x;
        int g;
    } exp_t;

    exp_t  sb[$];
    event  sample_ev;
    int    n_chk = 0;
    int    n_err = 0;
    string tag = "";
    int    c_scan, c_bse, c_vbt, c_ext, c_first_odd;

    function automatic int par_of(int f);
        return (c_first_odd + f) % 2;
    endfunction

    function automatic int flen();
        if (c_bse == 0) return 21;
        if (c_vbt < 16) return 16;
        if (c_vbt > 127) return 127;
        return c_vbt;
    endfunction

    function automatic int foff(int p);
        int l = flen();
        if (l <= 21) return 0;
        return (p != 0) ? (l - 21) / 2 : (l - 20) / 2;
    endfunction

    function automatic int lead_of(int p);
        int v = c_vbt % 128;
        if (c_bse == 0) return 4;
        return (p != 0) ? (v + 1) / 2 : v / 2;
    endfunction

    function automatic int trail_of(int p);
        int v = c_vbt % 128;
        if (c_bse == 0) return 4;
        return (p != 0) ? v / 2 : (v + 1) / 2;
    endfunction

    function automatic void span(int f, output int s, output int e);
        if (c_scan == 0) begin
            s = f * NL + NL - 1 - foff(par_of(f));
            e = s + flen();
        end else begin
            s = f * NL + BLN - lead_of(par_of(f));
            e = (f + 1) * NL + CLN + trail_of(par_of(f + 1));
        end
    endfunction

    function automatic bit exp_main(int g);
        int s, e;
        for (int f = 0; f <= FIELDS; f++) begin
            span(f, s, e);
            if (g >= s && g < e) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic bit exp_ext(int g);
        int s, e;
        if (exp_main(g)) return 1'b1;
        if (c_ext == 0) return 1'b0;
        for (int f = 0; f <= FIELDS; f++) begin
            span(f, s, e);
            if (g >= e && g < e + 6) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic chk(bit act, bit exp, string what, int g);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s line %0d act %0b exp %0b", tag, what, g, act, exp);
        end
    endtask

    // monitor: pops expected items one clock after each line tick (R1 latency)
    initial begin
        forever begin
            exp_t it;
            @(sample_ev);
            if (sb.size() == 0) begin
                chk(1'b1, 1'b0, "empty scoreboard", -1);
            end else begin
                it = sb.pop_front();
                chk(vblank, it.m, "vblank", it.g);
                chk(vblank_ext, it.x, "vblank_ext", it.g);
            end
        end
    end

    task automatic run_case(string t, int sc, int be, int vb, int ee, int fo);
        tag = t;
        c_scan = sc; c_bse = be; c_vbt = vb; c_ext = ee; c_first_odd = fo;
        @(negedge clk);
        rst_n = 1'b0;
        line_tick = 1'b0;
        vsync_evt = 1'b0;
        mode_scan = 1'(sc);
        bsel_en = 1'(be);
        blank_len = 8'(vb);
        ext_en = 1'(ee);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(vblank, 1'b0, "R1 reset vblank", -1);
        chk(vblank_ext, 1'b0, "R1 reset vblank_ext", -1);
        for (int g = 0; g < FIELDS * NL; g++) begin
            int l = g % NL;
            int f = g / NL;
            bit p = (par_of(f) != 0);
            exp_t it;
            line_tick = 1'b1;
            line_num  = 10'(l);
            vsync_evt = (l == 0);
            // R11: opposite parity on every non-vsync line must be ignored
            field_odd = (l == 0) ? p : !p;
            it.m = exp_main(g);
            it.x = exp_ext(g);
            it.g = g;
            sb.push_back(it);
            @(negedge clk);
            line_tick = 1'b0;
            vsync_evt = 1'b0;
            -> sample_ev;
            @(negedge clk);
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    bit done = 1'b0;

    initial begin
        run_case("R1/R3/R4/R11 fixed default",      0, 0, 90,  0, 1);
        run_case("R2/R4 fixed clamp low",            0, 1, 3,   1, 0);
        run_case("R2/R5/R10 fixed clamp high",       0, 1, 200, 1, 1);
        run_case("R5/R11 fixed len 26",              0, 1, 26,  0, 1);
        run_case("R5/R11 fixed len 25",              0, 1, 25,  1, 0);
        run_case("R6/R10 scan ext 0",                1, 1, 0,   1, 1);
        run_case("R7/R11 scan ext 7",                1, 1, 7,   0, 1);
        run_case("R8/R7 scan ext 135",               1, 1, 135, 1, 0);
        run_case("R9/R10 scan default",              1, 0, 50,  1, 1);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired in %s", tag);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule